// File: doc/BRIEF.md
# Bit-Sorting Majority Voter

This block decides whether a strict majority of its N input bits are 1. It does not count the ones with an adder tree, and it does not expand the vote into a sum of products. Instead the bits pass through a fixed network of two-bit compare-exchange cells. Each cell is one OR gate and one AND gate. The OR output carries the larger bit toward the top of the vector and the AND output carries the smaller bit toward the bottom. When the network is done, every 1 sits above every 0. The vote is then a single wire: the position in the sorted vector that equals the threshold, counted from the top.

The block is built for 4 or 8 inputs. It is used where many parity sums must be voted on at once, for example in a one-step majority-logic corrector. The whole sorted vector is brought out so that the ordering can be watched.

Results move through a valid/ready stream. With `REG_OUT = 1`, a single output register holds the vote and the sorted vector. A word is accepted when `in_valid` and `in_ready` are both high on a clock edge. `in_ready` is high whenever the register is empty or the consumer is taking its word in the same cycle. While `out_valid` is high and `out_ready` is low, the held word does not change and no new word is taken. With `REG_OUT = 0`, the path is purely combinational and the handshake passes straight through.

Top module: `maj_sort_gate`

## Requirements
- R1: Bit 0 of `out_sorted` is the top of the sorted vector. For an input with c ones, `out_sorted` has bits 0 to c-1 set and all other bits clear. The vector is therefore always all ones above all zeros.
- R2: `out_maj` is 1 exactly when the number of ones in the input is at least THRESH. THRESH defaults to N/2+1, which is 5 of 8 and 3 of 4. With 8 inputs, a count of 4 gives 0 and a count of 5 gives 1.
- R3: `out_maj` always equals `out_sorted[THRESH-1]`.
- R4: With `REG_OUT = 1`, a word accepted at a clock edge appears on `out_maj`, `out_sorted` and `out_valid` right after that edge. That is one cycle of latency. With `REG_OUT = 0`, the outputs follow the inputs in the same cycle.
- R5: While `rst_n` is low, the output register clears: `out_valid`, `out_maj` and every bit of `out_sorted` are 0.
- R6: With `REG_OUT = 1`, while `out_valid` is high and `out_ready` is low, the outputs hold their values from one cycle to the next. During that time `in_ready` is low and a new word offered on `in_bits` is not taken.
- R7: With `REG_OUT = 1`, `in_ready` equals `!out_valid || out_ready`. With `REG_OUT = 0`, `in_ready` equals `out_ready` and `out_valid` equals `in_valid`.
- R8: With `REG_OUT = 1`, when the held word is consumed and no new word is accepted at the same edge, `out_valid` falls after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Used only when REG_OUT = 1. |
| rst_n | input | 1 | Active-low synchronous reset for the output register. |
| in_valid | input | 1 | `in_bits` holds a word to vote on. |
| in_ready | output | 1 | The block can accept a word this cycle. |
| in_bits | input | N | Bits to be voted on. |
| out_valid | output | 1 | `out_maj` and `out_sorted` hold a result. |
| out_ready | input | 1 | The consumer takes the result this cycle. |
| out_maj | output | 1 | Majority decision. |
| out_sorted | output | N | Input bits sorted with ones first; bit 0 is the top. |

## Verification
Most internal faults show up on `out_sorted` for the input patterns that exercise them. A miswired or inverted compare cell, or a swapped pair, breaks the ones-above-zeros shape or changes the number of ones in the vector. This is visible in the same cycle in the combinational variant and one edge later in the registered one. Because every input pattern is applied, any such fault is reached. A wrong tap for the vote shows as `out_maj` disagreeing with the threshold, and it shows only at counts next to the threshold. A faulty hold or enable in the output register shows only under back-pressure. It appears as the held word changing, or being overwritten by the stalled input, at the first edge where `out_ready` is low.

// File: rtl/maj_sort_pkg.sv
`timescale 1ns/1ps
package maj_sort_pkg;

  // number of compare-exchange cells for a supported width
  function automatic int unsigned net_cells(input int unsigned n);
    return (n == 4) ? 5 : 19;
  endfunction

  // upper lane of cell k (receives the OR)
  function automatic int unsigned cell_hi(input int unsigned n, input int unsigned k);
    int unsigned h4 [5]  = '{0, 2, 0, 1, 1};
    int unsigned h8 [19] = '{0, 2, 4, 6, 0, 1, 4, 5, 1, 5, 0, 1, 2, 3, 2, 3, 1, 3, 5};
    return (n == 4) ? h4[k % 5] : h8[k % 19];
  endfunction

  // lower lane of cell k (receives the AND)
  function automatic int unsigned cell_lo(input int unsigned n, input int unsigned k);
    int unsigned l4 [5]  = '{1, 3, 2, 3, 2};
    int unsigned l8 [19] = '{1, 3, 5, 7, 2, 3, 6, 7, 2, 6, 4, 5, 6, 7, 4, 5, 2, 4, 6};
    return (n == 4) ? l4[k % 5] : l8[k % 19];
  endfunction

endpackage

// File: rtl/maj_cmp_cell.sv
`timescale 1ns/1ps
module maj_cmp_cell (
  input  logic a,
  input  logic b,
  output logic hi,
  output logic lo
);
  // larger bit goes up, smaller bit goes down
  assign hi = a | b;
  assign lo = a & b;
endmodule

// File: rtl/maj_sort_net.sv
`timescale 1ns/1ps
module maj_sort_net #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] bits_i,
  output logic [N-1:0] sorted_o
);
  localparam int unsigned NCELL = maj_sort_pkg::net_cells(N);

  logic lane [NCELL+1][N];

  for (genvar j = 0; j < N; j++) begin : g_io
    assign lane[0][j]  = bits_i[j];
    assign sorted_o[j] = lane[NCELL][j];
  end

  for (genvar k = 0; k < NCELL; k++) begin : g_cell
    localparam int unsigned UP = maj_sort_pkg::cell_hi(N, k);
    localparam int unsigned DN = maj_sort_pkg::cell_lo(N, k);

    maj_cmp_cell u_cell (
      .a  (lane[k][UP]),
      .b  (lane[k][DN]),
      .hi (lane[k+1][UP]),
      .lo (lane[k+1][DN])
    );

    for (genvar j = 0; j < N; j++) begin : g_pass
      if (j != UP && j != DN) begin : g_wire
        assign lane[k+1][j] = lane[k][j];
      end
    end
  end
endmodule

// File: rtl/maj_out_stage.sv
`timescale 1ns/1ps
module maj_out_stage #(
  parameter int unsigned W   = 9,
  parameter bit          REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_word,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_word
);
  if (REG) begin : g_reg
    logic         held_q;
    logic [W-1:0] word_q;
    logic         take;

    assign in_ready = !held_q || out_ready;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        held_q <= 1'b0;
        word_q <= '0;
      end else begin
        if (take) begin
          word_q <= in_word;
          held_q <= 1'b1;
        end else if (out_ready) begin
          held_q <= 1'b0;
        end
      end
    end

    assign out_valid = held_q;
    assign out_word  = word_q;
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_word  = in_word;
  end
endmodule

// File: rtl/maj_sort_gate.sv
`timescale 1ns/1ps
module maj_sort_gate #(
  parameter int unsigned N       = 8,
  parameter bit          REG_OUT = 1'b1,
  parameter int unsigned THRESH  = N / 2 + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] in_bits,
  output logic         out_valid,
  input  logic         out_ready,
  output logic         out_maj,
  output logic [N-1:0] out_sorted
);
  localparam int unsigned W = N + 1;

  logic [N-1:0] sorted_c;
  logic [W-1:0] word_c;
  logic [W-1:0] word_q;

  maj_sort_net #(.N(N)) u_net (
    .bits_i   (in_bits),
    .sorted_o (sorted_c)
  );

  // vote is the THRESH-th position from the top of the sorted vector
  assign word_c = {sorted_c[THRESH-1], sorted_c};

  maj_out_stage #(.W(W), .REG(REG_OUT)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_word   (word_c),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (word_q)
  );

  assign out_maj    = word_q[N];
  assign out_sorted = word_q[N-1:0];
endmodule

// File: rtl/maj_sort_gate_chk.sv
`timescale 1ns/1ps
module maj_sort_gate_chk #(
  parameter int unsigned N       = 8,
  parameter bit          REG_OUT = 1'b1,
  parameter int unsigned THRESH  = N / 2 + 1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [N-1:0] in_bits,
  input logic         out_valid,
  input logic         out_ready,
  input logic         out_maj,
  input logic [N-1:0] out_sorted
);
  // no zero may sit above a one
  assert_monotone_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_sorted >> 1) & ~out_sorted) == '0);

  assert_vote_tap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_maj == out_sorted[THRESH-1]);

  if (REG_OUT) begin : g_reg
    assert_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

    assert_vote_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_maj == ($countones($past(in_bits)) >= THRESH)));

    assert_reset_clear_R5: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && !out_maj && out_sorted == '0));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_sorted) && $stable(out_maj)));

    assert_ready_rule_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready == (!out_valid || out_ready));

    assert_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !in_valid) |=> !out_valid);
  end else begin : g_comb
    assert_vote_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_maj == ($countones(in_bits) >= THRESH));

    assert_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid == in_valid) && (in_ready == out_ready));
  end
endmodule

bind maj_sort_gate maj_sort_gate_chk #(.N(N), .REG_OUT(REG_OUT), .THRESH(THRESH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_bits    (in_bits),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_maj    (out_maj),
  .out_sorted (out_sorted)
);

// File: tb/maj_sort_gate_bench.sv
`timescale 1ns/1ps
module maj_sort_gate_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  // registered 8-input instance
  logic       in_valid = 1'b0, out_ready = 1'b0;
  logic       in_ready, out_valid, out_maj;
  logic [7:0] in_bits = '0, out_sorted;

  // combinational 4-input instance
  logic       c_in_valid = 1'b0, c_out_ready = 1'b0;
  logic       c_in_ready, c_out_valid, c_out_maj;
  logic [3:0] c_in_bits = '0, c_out_sorted;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  maj_sort_gate u_maj_sort_gate (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bits(in_bits), .out_valid(out_valid), .out_ready(out_ready),
    .out_maj(out_maj), .out_sorted(out_sorted)
  );

  maj_sort_gate #(.N(4), .REG_OUT(1'b0)) u_maj_sort_gate_c4 (
    .clk(clk), .rst_n(rst_n), .in_valid(c_in_valid), .in_ready(c_in_ready),
    .in_bits(c_in_bits), .out_valid(c_out_valid), .out_ready(c_out_ready),
    .out_maj(c_out_maj), .out_sorted(c_out_sorted)
  );

  function automatic int ones(input logic [7:0] v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += int'(v[i]);
    return c;
  endfunction

  function automatic logic [7:0] therm(input int c);
    logic [7:0] t = '0;
    for (int i = 0; i < 8; i++) if (i < c) t[i] = 1'b1;
    return t;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R5", "out_valid in reset", 32'(out_valid), 0);
    check("R5", "out_maj in reset", 32'(out_maj), 0);
    check("R5", "out_sorted in reset", 32'(out_sorted), 0);
  endtask

  task automatic t_all_patterns_reg();
    out_ready = 1'b1;
    for (int p = 0; p < 256; p++) begin
      @(negedge clk);
      in_bits  = 8'(p);
      in_valid = 1'b1;
      #1;
      check("R7", "in_ready when draining", 32'(in_ready), 1);
      @(negedge clk);
      check("R4", "out_valid one cycle later", 32'(out_valid), 1);
      check("R1", "sorted thermometer", 32'(out_sorted), 32'(therm(ones(8'(p)))));
      check("R2", "vote of 8", 32'(out_maj), 32'(ones(8'(p)) >= 5));
      check("R3", "vote equals sorted[4]", 32'(out_maj), 32'(out_sorted[4]));
    end
    in_valid = 1'b0;
  endtask

  task automatic t_threshold_edges();
    out_ready = 1'b1;
    @(negedge clk);
    in_bits = 8'b1011_0100;
    in_valid = 1'b1;
    @(negedge clk);
    check("R2", "count 4 gives 0", 32'(out_maj), 0);
    in_bits = 8'b1011_0101;
    @(negedge clk);
    check("R2", "count 5 gives 1", 32'(out_maj), 1);
    in_valid = 1'b0;
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    out_ready = 1'b0;
    in_bits = 8'b1111_1000;
    in_valid = 1'b1;
    @(negedge clk);
    check("R4", "stalled word captured", 32'(out_sorted), 32'(8'b0001_1111));
    in_bits = 8'b0000_0001;
    #1;
    check("R6", "in_ready low when full", 32'(in_ready), 0);
    check("R7", "in_ready rule under stall", 32'(in_ready), 0);
    @(negedge clk);
    check("R6", "held sorted vector", 32'(out_sorted), 32'(8'b0001_1111));
    check("R6", "held vote", 32'(out_maj), 1);
    check("R6", "held valid", 32'(out_valid), 1);
    out_ready = 1'b1;
    #1;
    check("R7", "in_ready follows out_ready", 32'(in_ready), 1);
    @(negedge clk);
    check("R6", "next word after release", 32'(out_sorted), 32'(8'b0000_0001));
    check("R6", "next vote after release", 32'(out_maj), 0);
    in_valid = 1'b0;
  endtask

  task automatic t_drain();
    out_ready = 1'b1;
    @(negedge clk);
    in_bits = 8'hFF;
    in_valid = 1'b1;
    @(negedge clk);
    check("R4", "word present", 32'(out_valid), 1);
    in_valid = 1'b0;
    in_bits = 8'h00;
    @(negedge clk);
    check("R8", "valid falls after drain", 32'(out_valid), 0);
  endtask

  task automatic t_all_patterns_comb();
    for (int p = 0; p < 16; p++) begin
      @(negedge clk);
      c_in_bits   = 4'(p);
      c_in_valid  = p[0];
      c_out_ready = p[1];
      #5;
      check("R4", "comb sorted same cycle", 32'(c_out_sorted), 32'(therm(ones(8'(p))) & 8'h0F));
      check("R2", "vote of 4", 32'(c_out_maj), 32'(ones(8'(p)) >= 3));
      check("R7", "comb valid passthrough", 32'(c_out_valid), 32'(p[0]));
      check("R7", "comb ready passthrough", 32'(c_in_ready), 32'(p[1]));
    end
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    t_reset();
    rst_n = 1'b1;
    t_all_patterns_reg();
    t_threshold_edges();
    t_backpressure();
    t_drain();
    t_all_patterns_comb();
    @(negedge clk);
    summary();
  end

  initial begin
    #(20 * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end
endmodule